// File: doc/BRIEF.md
# Command-Driven Interval Timer

This block is a down-counting interval timer that sits beside the channels of a serial controller and is driven through a small byte-wide register bus. Software programs a 16-bit reload value as two byte registers. It then steers the timer by writing short command codes into a control register. The commands start and stop the timer, choose single-event or periodic operation, and pick the counting clock. That clock is either a tick from the internal oscillator or a tick from an external timer pin.

The counter advances only on cycles where the selected tick input is high. When a decrement brings the count to zero, the block drives a one-cycle timeout pulse and latches an interrupt. Reading the control register returns that pending interrupt in bit 0 and clears it. The reload registers always read back the programmed value, never the live count. Both tick inputs are treated as synchronous clock enables.

Top module: `cmd_interval_timer`

## Requirements
- R1: After reset, both reload bytes read 0x00, the control register reads 0x00, and irqOut and timeoutOut are low. The default mode is one-shot on the internal tick.
- R2: Address 0 holds reload bits 7:0 and address 1 holds reload bits 15:8. A read of either address returns the written byte, including while the counter is running.
- R3: A write to address 2 decodes bits 3:0 as follows: 0x1 start, 0x2 stop, 0x3 one-shot, 0x4 periodic, 0x5 internal tick, 0x6 external tick. Bits 7:4 are ignored. Any other code has no effect, and a control read never shows the written code.
- R4: A start with reload N (N nonzero) loads the counter with N. timeoutOut is high for exactly the one cycle after the clock edge that sampled the N-th selected tick.
- R5: In one-shot mode the timer produces one timeout and then stays idle until the next start.
- R6: In periodic mode the counter reloads on each timeout, giving a timeout every N selected ticks.
- R7: Only the selected tick source (oscTick or extTick) advances the counter.
- R8: A reload value of zero disables the timer. A start is then ignored and no timeout occurs.
- R9: A control read returns 0x01 while an interrupt is pending and 0x00 otherwise, and it clears the pending flag. A timeout at the same edge as such a read leaves the flag set.
- R10: A stop freezes counting without clearing a pending interrupt. A later start reloads from the reload value.
- R11: A start while running restarts the count from the reload value.
- R12: A reload write while running does not disturb the current count. It is used at the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a control read clears the interrupt) |
| regAddr | input | 2 | Register address: 0 reload low, 1 reload high, 2 control |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from the address |
| oscTick | input | 1 | Internal oscillator tick enable |
| extTick | input | 1 | External timer pin tick enable |
| irqOut | output | 1 | Pending timer interrupt |
| timeoutOut | output | 1 | One-cycle pulse on each timeout |

## Verification
The bench counts timeouts tick by tick, which catches an off-by-one count: a faulty design would fire at tick N-1 or N+1. The same counting exposes a one-shot timer that keeps firing, and a periodic timer that stops after its first period.

Further cases target specific faults:
- Idle ticks on the unselected source would reveal a design that ignores the clock selection.
- A zero reload exposes a timer that fires immediately or wraps through 65535.
- Illegal command codes, and codes with the upper nibble set, expose a design that decodes too loosely or too strictly.
- A timeout that lands on the same edge as a control read catches a design that lets the clear win and drops the event.
- Stop with an interrupt pending catches a stop that wipes the flag.
- Restarting mid-count and rewriting the reload mid-count show whether the counter is reloaded at the wrong moment.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int TMR_W     = 16;
  localparam int BUS_W     = 8;
  localparam int ADDR_W    = 2;
  localparam int TMR_BYTES = TMR_W / BUS_W;
  localparam int CTRL_ADDR = TMR_BYTES;
  localparam int CMD_W     = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE    = 4'h0,
    CMD_START   = 4'h1,
    CMD_STOP    = 4'h2,
    CMD_ONESHOT = 4'h3,
    CMD_PERIOD  = 4'h4,
    CMD_INTCLK  = 4'h5,
    CMD_EXTCLK  = 4'h6
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [TMR_BYTES-1:0] wrByte;
    logic                 loadCnt;
    logic                 decCnt;
  } dp_strobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CMD_W-1:0]  cmdCode,
  input  logic              oscTick,
  input  logic              extTick,
  input  logic              cntIsOne,
  input  logic              reloadIsZero,
  output dp_strobe_t        strobe,
  output logic              running,
  output logic              irqPending,
  output logic              timeoutPulse
);
  logic selExt;
  logic periodic;
  logic ctrlWr;
  logic ctrlRd;
  logic isStart, isStop, isOneShot, isPeriod, isIntClk, isExtClk;
  logic rawTick;
  logic cntTick;
  logic expire;
  logic startOk;

  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));
  assign ctrlRd = regRdEn && (regAddr == ADDR_W'(CTRL_ADDR));

  assign isStart   = ctrlWr && (cmdCode == CMD_START);
  assign isStop    = ctrlWr && (cmdCode == CMD_STOP);
  assign isOneShot = ctrlWr && (cmdCode == CMD_ONESHOT);
  assign isPeriod  = ctrlWr && (cmdCode == CMD_PERIOD);
  assign isIntClk  = ctrlWr && (cmdCode == CMD_INTCLK);
  assign isExtClk  = ctrlWr && (cmdCode == CMD_EXTCLK);

  assign rawTick = selExt ? extTick : oscTick;
  // a start or stop in the same cycle overrides the tick
  assign cntTick = running && rawTick && !isStart && !isStop;
  assign expire  = cntTick && cntIsOne;
  assign startOk = isStart && !reloadIsZero;

  genvar b;
  generate
    for (b = 0; b < TMR_BYTES; b++) begin : g_wr
      assign strobe.wrByte[b] = regWrEn && (regAddr == ADDR_W'(b));
    end
  endgenerate

  always_comb begin
    strobe.loadCnt = startOk || (expire && periodic);
    strobe.decCnt  = cntTick && !strobe.loadCnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selExt   <= 1'b0;
      periodic <= 1'b0;
    end else begin
      if (isExtClk)      selExt <= 1'b1;
      else if (isIntClk) selExt <= 1'b0;
      if (isPeriod)       periodic <= 1'b1;
      else if (isOneShot) periodic <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
    end else if (isStart) begin
      running <= startOk;
    end else if (isStop) begin
      running <= 1'b0;
    end else if (expire && (!periodic || reloadIsZero)) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqPending   <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= expire;
      if (expire)      irqPending <= 1'b1;
      else if (ctrlRd) irqPending <= 1'b0;
    end
  end
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dp_strobe_t       strobe,
  input  logic [BUS_W-1:0] wrData,
  output logic [TMR_W-1:0] reloadVal,
  output logic             cntIsOne,
  output logic             reloadIsZero
);
  logic [BUS_W-1:0] reloadByte [TMR_BYTES];
  logic [TMR_W-1:0] count;

  genvar b;
  generate
    for (b = 0; b < TMR_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)               reloadByte[b] <= '0;
        else if (strobe.wrByte[b]) reloadByte[b] <= wrData;
      end
      assign reloadVal[b*BUS_W +: BUS_W] = reloadByte[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (strobe.loadCnt) count <= reloadVal;
    else if (strobe.decCnt)  count <= count - 1'b1;
  end

  assign cntIsOne     = (count == TMR_W'(1));
  assign reloadIsZero = (reloadVal == '0);
endmodule

// File: rtl/cmd_interval_timer.sv
module cmd_interval_timer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              oscTick,
  input  logic              extTick,
  output logic              irqOut,
  output logic              timeoutOut
);
  dp_strobe_t       strobe;
  logic [TMR_W-1:0] reloadVal;
  logic             cntIsOne;
  logic             reloadIsZero;
  logic             timerRunning;
  logic             irqPending;
  logic             timeoutPulse;

  timer_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regAddr      (regAddr),
    .cmdCode      (regWrData[CMD_W-1:0]),
    .oscTick      (oscTick),
    .extTick      (extTick),
    .cntIsOne     (cntIsOne),
    .reloadIsZero (reloadIsZero),
    .strobe       (strobe),
    .running      (timerRunning),
    .irqPending   (irqPending),
    .timeoutPulse (timeoutPulse)
  );

  timer_dp u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .wrData       (regWrData),
    .reloadVal    (reloadVal),
    .cntIsOne     (cntIsOne),
    .reloadIsZero (reloadIsZero)
  );

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < TMR_BYTES; b++) begin
      if (regAddr == ADDR_W'(b)) regRdData = reloadVal[b*BUS_W +: BUS_W];
    end
    if (regAddr == ADDR_W'(CTRL_ADDR)) regRdData = {{(BUS_W-1){1'b0}}, irqPending};
  end

  assign irqOut     = irqPending;
  assign timeoutOut = timeoutPulse;
endmodule

// File: rtl/timer_sva.sv
module timer_sva
  import timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [BUS_W-1:0]  regRdData,
  input logic              irqOut,
  input logic              timeoutOut,
  input logic              timerRunning
);
  logic ctrlRead;
  assign ctrlRead = regRdEn && (regAddr == ADDR_W'(CTRL_ADDR));

  // R4 / R9: every timeout pulse comes with a pending interrupt
  p_irq_with_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutOut |-> irqOut);

  // R9: a control read clears the flag unless a timeout lands on the same edge
  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRead |=> (timeoutOut || !irqOut));

  // R10: the flag holds until a control read
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut && !ctrlRead) |=> irqOut);

  // R9: the control read value tracks the interrupt output
  p_ctrl_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRead |-> (regRdData == {{(BUS_W-1){1'b0}}, irqOut}));

  // R5 / R8: no timeout while the timer is idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !timerRunning |=> !timeoutOut);
endmodule

bind cmd_interval_timer timer_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .regRdEn      (regRdEn),
  .regAddr      (regAddr),
  .regRdData    (regRdData),
  .irqOut       (irqOut),
  .timeoutOut   (timeoutOut),
  .timerRunning (timerRunning)
);

// File: tb/cmd_interval_timer_tb.sv
`timescale 1ns/1ps
module cmd_interval_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       oscTick = 1'b0;
  logic       extTick = 1'b0;
  logic       irqOut;
  logic       timeoutOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cmd_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .oscTick(oscTick), .extTick(extTick), .irqOut(irqOut), .timeoutOut(timeoutOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // issue n ticks on one source, count timeouts and note the tick index of each
  task automatic ticks(input int n, input bit ext, output int hits, output int firstAt, output int lastAt);
    hits = 0; firstAt = 0; lastAt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (ext) extTick = 1'b1; else oscTick = 1'b1;
      @(negedge clk);
      extTick = 1'b0; oscTick = 1'b0;
      if (timeoutOut) begin
        hits++;
        if (firstAt == 0) firstAt = i;
        lastAt = i;
      end
    end
  endtask

  task automatic setReload(input int v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic cleanUp();
    logic [7:0] d;
    wr(2'd2, 8'h02);
    wr(2'd2, 8'h03);
    wr(2'd2, 8'h05);
    rd(2'd2, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 reload low", d, 0);
    rd(2'd1, d); check("R1 reload high", d, 0);
    rd(2'd2, d); check("R1 ctrl", d, 0);
    check("R1 irqOut", irqOut, 0);
    check("R1 timeoutOut", timeoutOut, 0);
  endtask

  task automatic t_reload_rw();
    logic [7:0] d; int h, f, l;
    setReload(16'h1234);
    rd(2'd0, d); check("R2 low byte", d, 8'h34);
    rd(2'd1, d); check("R2 high byte", d, 8'h12);
    wr(2'd2, 8'h01);
    ticks(3, 1'b0, h, f, l);
    rd(2'd0, d); check("R2 low byte while running", d, 8'h34);
    rd(2'd1, d); check("R2 high byte while running", d, 8'h12);
    cleanUp();
  endtask

  task automatic t_oneshot();
    logic [7:0] d; int h, f, l;
    setReload(5);
    wr(2'd2, 8'h03);
    wr(2'd2, 8'h01);
    ticks(12, 1'b0, h, f, l);
    check("R5 one-shot timeout count", h, 1);
    check("R4 timeout at tick N", f, 5);
    rd(2'd2, d); check("R9 ctrl reads pending", d, 1);
    rd(2'd2, d); check("R9 ctrl cleared by read", d, 0);
    check("R9 irqOut low after read", irqOut, 0);
    cleanUp();
  endtask

  task automatic t_periodic();
    int h, f, l;
    setReload(3);
    wr(2'd2, 8'h04);
    wr(2'd2, 8'h01);
    ticks(9, 1'b0, h, f, l);
    check("R6 periodic count", h, 3);
    check("R6 first period", f, 3);
    check("R6 last period", l, 9);
    cleanUp();
  endtask

  task automatic t_clksel();
    int h, f, l;
    setReload(2);
    wr(2'd2, 8'h06);
    wr(2'd2, 8'h01);
    ticks(4, 1'b0, h, f, l);
    check("R7 internal tick ignored when external selected", h, 0);
    ticks(2, 1'b1, h, f, l);
    check("R7 external tick counts", f, 2);
    wr(2'd2, 8'h05);
    wr(2'd2, 8'h01);
    ticks(3, 1'b1, h, f, l);
    check("R7 external tick ignored when internal selected", h, 0);
    ticks(2, 1'b0, h, f, l);
    check("R7 internal tick counts", f, 2);
    cleanUp();
  endtask

  task automatic t_zero();
    logic [7:0] d; int h, f, l;
    setReload(0);
    wr(2'd2, 8'h04);
    wr(2'd2, 8'h01);
    ticks(6, 1'b0, h, f, l);
    check("R8 zero reload no timeout", h, 0);
    rd(2'd2, d); check("R8 no interrupt", d, 0);
    cleanUp();
  endtask

  task automatic t_stop();
    logic [7:0] d; int h, f, l;
    setReload(4);
    wr(2'd2, 8'h01);
    ticks(4, 1'b0, h, f, l);
    check("R10 first timeout", f, 4);
    wr(2'd2, 8'h01);
    ticks(2, 1'b0, h, f, l);
    wr(2'd2, 8'h02);
    ticks(6, 1'b0, h, f, l);
    check("R10 stop freezes", h, 0);
    check("R10 irq kept over stop", irqOut, 1);
    rd(2'd2, d); check("R10 ctrl still pending", d, 1);
    wr(2'd2, 8'h01);
    ticks(4, 1'b0, h, f, l);
    check("R10 start after stop reloads", f, 4);
    cleanUp();
  endtask

  task automatic t_restart();
    int h, f, l;
    setReload(4);
    wr(2'd2, 8'h01);
    ticks(3, 1'b0, h, f, l);
    wr(2'd2, 8'h01);
    ticks(4, 1'b0, h, f, l);
    check("R11 restart count", h, 1);
    check("R11 restart position", f, 4);
    cleanUp();
  endtask

  task automatic t_badcmd();
    logic [7:0] d; int h, f, l;
    setReload(3);
    wr(2'd2, 8'h07);
    wr(2'd2, 8'h0F);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h08);
    ticks(5, 1'b0, h, f, l);
    check("R3 illegal codes ignored", h, 0);
    wr(2'd2, 8'hF1);
    rd(2'd2, d); check("R3 ctrl hides command", d, 0);
    ticks(3, 1'b0, h, f, l);
    check("R3 upper nibble ignored", f, 3);
    cleanUp();
  endtask

  task automatic t_reload_change();
    int h, f, l;
    setReload(3);
    wr(2'd2, 8'h04);
    wr(2'd2, 8'h01);
    ticks(1, 1'b0, h, f, l);
    setReload(5);
    ticks(2, 1'b0, h, f, l);
    check("R12 current period unchanged", f, 2);
    ticks(5, 1'b0, h, f, l);
    check("R12 new period used", h, 1);
    check("R12 new period position", f, 5);
    cleanUp();
  endtask

  task automatic t_race();
    logic [7:0] d;
    setReload(1);
    wr(2'd2, 8'h01);
    @(negedge clk);
    oscTick = 1'b1; regRdEn = 1'b1; regAddr = 2'd2;
    #1 d = regRdData;
    @(negedge clk);
    oscTick = 1'b0; regRdEn = 1'b0;
    check("R9 read before timeout returns 0", d, 0);
    check("R9 timeout on read edge", timeoutOut, 1);
    check("R9 set wins over clear", irqOut, 1);
    cleanUp();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reload_rw();
    t_oneshot();
    t_periodic();
    t_clksel();
    t_zero();
    t_stop();
    t_restart();
    t_badcmd();
    t_reload_change();
    t_race();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule